// File: doc/BRIEF.md
# Critical-Word-First Line Refill Tracker

This block runs one cache line refill at a time over a pipelined Wishbone read bus whose data path is one doubleword (64 bits) wide. When a load misses, the block takes the miss address, fetches the doubleword that load needs first, and then steps through the rest of the line, wrapping back to the start of the line. Every returned beat goes out through a registered write port toward the data RAM rows that hold the line. The same registered word also acts as the forwarding path to the loads that are waiting for it.

The block keeps one valid flag for each doubleword of the line in flight. The missing load finishes on the cycle after its beat is acknowledged. A later load to the same line can be offered on the load port in any cycle. It finishes as soon as its doubleword has landed, even if other beats of the line are still outstanding. A load whose doubleword has not landed yet is held. The requester keeps presenting it until it finishes. When the last beat is acknowledged, the block pulses line-done and becomes free for the next miss.

Addresses are byte addresses. Bits [2:0] are the byte offset inside a doubleword. Bits [5:3] select one of the 8 doublewords of a 64-byte line. Bits [31:6] identify the line.

Top module: `refill_tracker`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `wb_cyc`, `wb_stb`, `ram_we`, `crit_done`, `line_done`, `ld_done` and `ld_fwd` are all 0.
- R2: A refill starts on a clock edge where `miss_valid` is 1 and `busy` is 0. The block then captures the line (bits [31:6]) and the critical doubleword index (bits [5:3]) of `miss_addr`. A `miss_valid` seen while `busy` is 1 is ignored. `busy` is 1 from the cycle after the start until the cycle in which `line_done` is 1.
- R3: The first request carries the critical doubleword index. Each later request carries the previous index plus one, modulo 8, inside the same line. Exactly 8 requests are issued. `wb_stb` and `wb_adr` stay unchanged while `wb_stall` is 1. `wb_adr` bits [2:0] are 0.
- R4: `wb_cyc` equals `busy`. `wb_stb` is only ever 1 while `wb_cyc` is 1.
- R5: All 8 valid flags are cleared when a refill starts. The k-th acknowledge of a refill (k counted from 0) sets the flag of doubleword (critical + k) mod 8.
- R6: On the cycle after each acknowledge, `ram_we` is 1. On that same cycle `ram_adr` equals the line concatenated with that beat's doubleword index, and `ram_wdata` equals the acknowledged `wb_dat_i`. In all other cycles `ram_we` is 0.
- R7: `crit_done` pulses for one cycle on the cycle after the first acknowledge of a refill. In that cycle the critical doubleword appears on `ram_wdata`.
- R8: A load whose line matches the refill in flight, and whose doubleword flag is already set, gets `ld_done`=1 with `ld_fwd`=0 on the next cycle.
- R9: A load whose line matches and whose doubleword is acknowledged in the same cycle gets `ld_done`=1 and `ld_fwd`=1 on the next cycle. Its data is on `ram_wdata` in that cycle.
- R10: A load gets no `ld_done` in the following cases: its doubleword is neither valid nor arriving; its line differs from the refill in flight; no refill is in flight.
- R11: `line_done` pulses for one cycle on the cycle after the 8th acknowledge. `busy` is 0 in that cycle, and a new miss can be accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Request to start a refill |
| miss_addr | input | 32 | Byte address of the missing load |
| busy | output | 1 | Refill in flight |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Read request strobe |
| wb_adr | output | 32 | Byte address of the current request |
| wb_stall | input | 1 | Bus cannot take a request this cycle |
| wb_ack | input | 1 | Read data beat returned |
| wb_dat_i | input | 64 | Read data |
| ram_we | output | 1 | Data RAM row write enable |
| ram_adr | output | 29 | Doubleword address of the row being written |
| ram_wdata | output | 64 | Row write data, also the forwarded word |
| crit_done | output | 1 | Missing load completes |
| line_done | output | 1 | Whole line received |
| ld_valid | input | 1 | Later load presented |
| ld_addr | input | 32 | Byte address of the later load |
| ld_done | output | 1 | Presented load completes |
| ld_fwd | output | 1 | Completed load takes its data from `ram_wdata` |

## Verification
The assertions assume a well-behaved bus slave. It acknowledges only requests it has already accepted, one beat per acknowledge, in issue order. It never raises `wb_ack` while `busy` is 0. The bench's slave model keeps a queue of accepted addresses and raises `wb_ack` only when that queue is non-empty. It returns the data for the oldest entry, so acknowledges never exceed requests. The stall and acknowledge patterns come from a pseudo-random sequence, and `miss_valid` and the loads are driven freely, including while a refill is busy.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_DATA_W     = 64;
  localparam int unsigned DEF_LINE_BEATS = 8;
endpackage

// File: rtl/refill_issue.sv
// Request sequencer: critical index first, then wrap through the line.
module refill_issue #(
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned LINE_BEATS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             stall,
  output logic             stb,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_BEATS - 1);

  logic [IDX_W-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb    <= 1'b0;
      idx    <= '0;
      sent_q <= '0;
    end else if (start) begin
      stb    <= 1'b1;
      idx    <= start_idx;
      sent_q <= '0;
    end else if (stb && !stall) begin
      sent_q <= sent_q + 1'b1;
      idx    <= idx + 1'b1;
      if (sent_q == LAST) stb <= 1'b0;
    end
  end

  // R3: the first request names the critical doubleword
  p_first_is_critical_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (stb && idx == $past(start_idx)));

  // R3: a stalled request is held unchanged
  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (stb && stall) |=> (stb && $stable(idx)));
endmodule

// File: rtl/refill_beats.sv
// Acknowledge side: beat index, valid flags, RAM write port, completion pulses.
module refill_beats #(
  parameter int unsigned TAG_W      = 26,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BEATS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [TAG_W-1:0]       start_line,
  input  logic [IDX_W-1:0]       start_idx,
  input  logic                   ack,
  input  logic [DATA_W-1:0]      dat,
  output logic                   busy,
  output logic [TAG_W-1:0]       line_q,
  output logic [LINE_BEATS-1:0]  valid_q,
  output logic                   ack_fire,
  output logic [IDX_W-1:0]       ack_idx,
  output logic                   ram_we,
  output logic [TAG_W+IDX_W-1:0] ram_adr,
  output logic [DATA_W-1:0]      ram_wdata,
  output logic                   crit_done,
  output logic                   line_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_BEATS - 1);

  logic [IDX_W-1:0] crit_q;
  logic [IDX_W-1:0] got_q;

  assign ack_fire = busy && ack;
  assign ack_idx  = crit_q + got_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      line_q    <= '0;
      crit_q    <= '0;
      got_q     <= '0;
      ram_we    <= 1'b0;
      ram_adr   <= '0;
      ram_wdata <= '0;
      crit_done <= 1'b0;
      line_done <= 1'b0;
    end else begin
      ram_we    <= ack_fire;
      crit_done <= ack_fire && (got_q == '0);
      line_done <= ack_fire && (got_q == LAST);
      if (ack_fire) begin
        ram_adr   <= {line_q, ack_idx};
        ram_wdata <= dat;
        got_q     <= got_q + 1'b1;
        if (got_q == LAST) busy <= 1'b0;
      end
      if (start) begin
        busy   <= 1'b1;
        line_q <= start_line;
        crit_q <= start_idx;
        got_q  <= '0;
      end
    end
  end

  for (genvar g = 0; g < LINE_BEATS; g++) begin : g_vbit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst || start)
        bit_q <= 1'b0;
      else if (ack_fire && ack_idx == IDX_W'(g))
        bit_q <= 1'b1;
    end
    assign valid_q[g] = bit_q;
  end

  // R4: input assumption, acknowledges come only inside a refill
  p_ack_inside_refill_r4: assert property (@(posedge clk) disable iff (rst)
    ack |-> busy);

  // R5: a new refill starts with no doubleword marked valid
  p_clear_on_start_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> (valid_q == '0));

  // R5: flags only accumulate while the refill runs
  p_flags_grow_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(valid_q) >= $past($countones(valid_q))));

  // R7: the critical beat is the word being written when the missing load completes
  p_crit_written_r7: assert property (@(posedge clk) disable iff (rst)
    crit_done |-> (ram_we && ram_adr[IDX_W-1:0] == crit_q));

  // R11: the line is complete and released when done pulses
  p_full_at_done_r11: assert property (@(posedge clk) disable iff (rst)
    line_done |-> ((&valid_q) && !busy));

  // R11: done is a single-cycle pulse
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);
endmodule

// File: rtl/refill_match.sv
// Load matcher: releases loads to the line in flight as their doubleword lands.
module refill_match #(
  parameter int unsigned TAG_W      = 26,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned LINE_BEATS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busy,
  input  logic [TAG_W-1:0]      line_q,
  input  logic [LINE_BEATS-1:0] valid_q,
  input  logic                  ack_fire,
  input  logic [IDX_W-1:0]      ack_idx,
  input  logic                  ld_valid,
  input  logic [TAG_W-1:0]      ld_line,
  input  logic [IDX_W-1:0]      ld_idx,
  output logic                  ld_done,
  output logic                  ld_fwd
);
  logic same_line, landed, arriving;

  always_comb begin
    same_line = ld_valid && busy && (ld_line == line_q);
    landed    = valid_q[ld_idx];
    arriving  = ack_fire && (ack_idx == ld_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_done <= 1'b0;
      ld_fwd  <= 1'b0;
    end else begin
      ld_done <= same_line && (landed || arriving);
      ld_fwd  <= same_line && arriving;
    end
  end

  // R8: a completion always answers a presented load
  p_done_needs_load_r8: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> $past(ld_valid));

  // R9: forwarding happens only on the cycle after an acknowledge
  p_fwd_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
    ld_fwd |-> $past(ack_fire));

  // R10: nothing completes when no refill is in flight
  p_idle_no_done_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !ld_done);
endmodule

// File: rtl/refill_tracker.sv
module refill_tracker
  import refill_pkg::*;
#(
  parameter  int unsigned ADDR_W     = DEF_ADDR_W,
  parameter  int unsigned DATA_W     = DEF_DATA_W,
  parameter  int unsigned LINE_BEATS = DEF_LINE_BEATS,
  localparam int unsigned OFF_W      = $clog2(DATA_W / 8),
  localparam int unsigned IDX_W      = $clog2(LINE_BEATS),
  localparam int unsigned TAG_W      = ADDR_W - IDX_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    busy,
  output logic                    wb_cyc,
  output logic                    wb_stb,
  output logic [ADDR_W-1:0]       wb_adr,
  input  logic                    wb_stall,
  input  logic                    wb_ack,
  input  logic [DATA_W-1:0]       wb_dat_i,
  output logic                    ram_we,
  output logic [ADDR_W-OFF_W-1:0] ram_adr,
  output logic [DATA_W-1:0]       ram_wdata,
  output logic                    crit_done,
  output logic                    line_done,
  input  logic                    ld_valid,
  input  logic [ADDR_W-1:0]       ld_addr,
  output logic                    ld_done,
  output logic                    ld_fwd
);
  logic                  start;
  logic [TAG_W-1:0]      line_q;
  logic [LINE_BEATS-1:0] valid_q;
  logic                  ack_fire;
  logic [IDX_W-1:0]      ack_idx;
  logic [IDX_W-1:0]      issue_idx;
  logic                  unused_low;

  assign start      = miss_valid && !busy;
  assign wb_cyc     = busy;
  assign wb_adr     = {line_q, issue_idx, {OFF_W{1'b0}}};
  assign unused_low = ^{miss_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

  refill_issue #(
    .IDX_W(IDX_W), .LINE_BEATS(LINE_BEATS)
  ) u_issue (
    .clk(clk), .rst(rst), .start(start),
    .start_idx(miss_addr[OFF_W +: IDX_W]),
    .stall(wb_stall), .stb(wb_stb), .idx(issue_idx)
  );

  refill_beats #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .LINE_BEATS(LINE_BEATS)
  ) u_beats (
    .clk(clk), .rst(rst), .start(start),
    .start_line(miss_addr[ADDR_W-1 -: TAG_W]),
    .start_idx(miss_addr[OFF_W +: IDX_W]),
    .ack(wb_ack), .dat(wb_dat_i),
    .busy(busy), .line_q(line_q), .valid_q(valid_q),
    .ack_fire(ack_fire), .ack_idx(ack_idx),
    .ram_we(ram_we), .ram_adr(ram_adr), .ram_wdata(ram_wdata),
    .crit_done(crit_done), .line_done(line_done)
  );

  refill_match #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_BEATS(LINE_BEATS)
  ) u_match (
    .clk(clk), .rst(rst), .busy(busy), .line_q(line_q), .valid_q(valid_q),
    .ack_fire(ack_fire), .ack_idx(ack_idx),
    .ld_valid(ld_valid),
    .ld_line(ld_addr[ADDR_W-1 -: TAG_W]),
    .ld_idx(ld_addr[OFF_W +: IDX_W]),
    .ld_done(ld_done), .ld_fwd(ld_fwd)
  );

  // R4: requests are issued only inside an open bus cycle
  p_stb_inside_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> wb_cyc);
endmodule

// File: tb/refill_tracker_test.sv
module refill_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        busy, wb_cyc, wb_stb;
  logic [31:0] wb_adr;
  logic        wb_stall = 1'b0;
  logic        wb_ack = 1'b0;
  logic [63:0] wb_dat_i = '0;
  logic        ram_we;
  logic [28:0] ram_adr;
  logic [63:0] ram_wdata;
  logic        crit_done, line_done;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        ld_done, ld_fwd;

  always #4 clk = ~clk;

  refill_tracker uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .busy(busy), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_adr(wb_adr),
    .wb_stall(wb_stall), .wb_ack(wb_ack), .wb_dat_i(wb_dat_i),
    .ram_we(ram_we), .ram_adr(ram_adr), .ram_wdata(ram_wdata),
    .crit_done(crit_done), .line_done(line_done),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .ld_fwd(ld_fwd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  bit          m_busy, m_stb;
  logic [25:0] m_line;
  int          m_crit, m_issued, m_acked, m_idx;
  bit          m_valid [8];
  bit          e_we, e_crit, e_done, e_ldd, e_ldf;
  logic [28:0] e_radr;
  logic [63:0] e_rdat;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a, ~a};
  endfunction

  always @(posedge clk) begin
    bit was_busy, af, leq;
    int ai, li;
    if (rst) begin
      m_busy = 0; m_stb = 0; m_line = '0; m_crit = 0; m_issued = 0;
      m_acked = 0; m_idx = 0;
      foreach (m_valid[i]) m_valid[i] = 0;
      e_we = 0; e_crit = 0; e_done = 0; e_ldd = 0; e_ldf = 0;
      e_radr = '0; e_rdat = '0;
    end else begin
      was_busy = m_busy;
      af  = m_busy && wb_ack;
      ai  = (m_crit + m_acked) % 8;
      li  = int'(ld_addr[5:3]);
      leq = (ld_addr[31:6] == m_line);
      e_we = af;
      if (af) begin
        e_radr = {m_line, 3'(ai)};
        e_rdat = wb_dat_i;
      end
      e_crit = af && (m_acked == 0);
      e_done = af && (m_acked == 7);
      e_ldd  = ld_valid && m_busy && leq && (m_valid[li] || (af && ai == li));
      e_ldf  = ld_valid && m_busy && leq && af && (ai == li);
      if (af) begin
        m_valid[ai] = 1;
        m_acked++;
        if (m_acked == 8) m_busy = 0;
      end
      if (m_stb && !wb_stall) begin
        m_issued++;
        if (m_issued == 8) m_stb = 0;
        else m_idx = (m_crit + m_issued) % 8;
      end
      if (!was_busy && miss_valid) begin
        m_busy = 1; m_stb = 1;
        m_line = miss_addr[31:6];
        m_crit = int'(miss_addr[5:3]);
        m_idx = m_crit; m_issued = 0; m_acked = 0;
        foreach (m_valid[i]) m_valid[i] = 0;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string lreq;
    chk("R2", "busy", 64'(busy), 64'(m_busy));
    chk("R4", "wb_cyc", 64'(wb_cyc), 64'(m_busy));
    chk("R3", "wb_stb", 64'(wb_stb), 64'(m_stb));
    if (m_stb) chk("R3", "wb_adr", 64'(wb_adr), 64'({m_line, 3'(m_idx), 3'b000}));
    chk("R6", "ram_we", 64'(ram_we), 64'(e_we));
    if (e_we) begin
      chk("R6", "ram_adr", 64'(ram_adr), 64'(e_radr));
      chk("R6", "ram_wdata", ram_wdata, e_rdat);
    end
    chk("R7", "crit_done", 64'(crit_done), 64'(e_crit));
    chk("R11", "line_done", 64'(line_done), 64'(e_done));
    // R5 flags decide R8 completions; R10 covers held and foreign loads
    lreq = e_ldf ? "R9" : (e_ldd ? "R5 R8" : "R10");
    chk(lreq, "ld_done", 64'(ld_done), 64'(e_ldd));
    chk("R9", "ld_fwd", 64'(ld_fwd), 64'(e_ldf));
  endtask

  // bus slave bookkeeping
  logic [31:0] q[$];
  logic        p_stb = 0, p_stall = 0, p_ack = 0;
  logic [31:0] p_adr = '0;
  logic [31:0] lf = 32'h1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs",
        64'({busy, wb_cyc, wb_stb, ram_we, crit_done, line_done, ld_done, ld_fwd}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "first cycle after reset",
        64'({busy, wb_cyc, wb_stb, ram_we, crit_done, line_done, ld_done, ld_fwd}), 64'(0));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int phase;
      phase = cyc / 1000;
      if (cyc > 0) @(negedge clk);
      compare_all();
      if (p_ack) void'(q.pop_front());
      if (p_stb && !p_stall) q.push_back(p_adr);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wb_stall = (phase == 1 || phase == 3) && (lf[1:0] == 2'b00);
      wb_ack   = (q.size() > 0) && ((phase == 0 || phase == 1) || lf[3:2] != 2'b00);
      wb_dat_i = (q.size() > 0) ? mem_word(q[0]) : 64'h0;
      miss_valid = (phase == 3) ? 1'b1 : (lf[9] & lf[12]);
      miss_addr  = {lf[31:14], 8'h00, lf[15:13], 3'b000};
      ld_valid   = lf[4];
      ld_addr    = {(lf[5] ? m_line : ~m_line), lf[8:6], 3'b000};
      p_stb = wb_stb; p_adr = wb_adr; p_stall = wb_stall; p_ack = wb_ack;
    end
    @(negedge clk);
    compare_all();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finish");
      summary();
      $finish;
    end
  end
endmodule